// File: doc/BRIEF.md
# PHY Test-Port Register Writer

This block performs one configuration write into the test/control port of a D-PHY receiver. A client presents an 8-bit test code (the PHY register address) and an 8-bit value, then pulses a start request. The block captures both operands and plays out a fixed sequence of levels on the port's clear, strobe, enable and data-in lines. The PHY takes the address on a falling strobe edge while enable is high. It takes the value on a rising strobe edge while enable is low.

The sequence has eight phases, and each phase holds its levels for `HOLD_CYCLES` system clocks (default 2). While the sequence runs, `busy` is high. A one-cycle `done` pulse follows the last phase. Start requests that arrive while a write is running are dropped. A typical use is loading the high-speed frequency-range select register, whose test code is 0x44, before the receiver is taken out of reset.

Top module: `phyTestWriter`

## Requirements
- R1: A start request sampled while idle captures `testCode` and `testData` and raises `busy` in the next cycle; that cycle is the first cycle of phase 0.
- R2: Phase 0 (clear) drives `phyClear` high while `phyStrobe`, `phyEnable` and `phyDin` are all zero.
- R3: Phase 1 drives every port line to zero. Phase 2 raises `phyStrobe` with `phyEnable` low and `phyDin` zero.
- R4: Phase 3 keeps `phyStrobe` high and puts the captured code on `phyDin` with `phyEnable` high. Phase 4 lowers `phyStrobe` while the code and the high enable are held, so the address is taken on the falling edge.
- R5: Phase 5 puts the captured value on `phyDin` with `phyEnable` and `phyStrobe` low. Phase 6 raises `phyStrobe` while the value is held with enable low, so the data is taken on the rising edge.
- R6: Phase 7 lowers `phyStrobe` while the value remains on `phyDin` with enable low. After phase 7 every port line returns to zero.
- R7: Whenever `busy` is low, `phyClear`, `phyStrobe`, `phyEnable` and `phyDin` are all zero. This is also the state after reset, together with `busy` and `done` low.
- R8: Each phase lasts exactly `HOLD_CYCLES` clocks, so `busy` stays high for exactly 8*`HOLD_CYCLES` cycles. `done` is high for exactly one cycle, the first cycle after `busy` falls.
- R9: A start request while `busy` is high is ignored. The running write keeps its captured operands, its length does not change, and no second write follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request to begin a write, sampled each clock |
| testCode | input | CODE_W | PHY register address, captured on an accepted start |
| testData | input | CODE_W | Value to write, captured on an accepted start |
| phyClear | output | 1 | Test-port clear line |
| phyStrobe | output | 1 | Test-port strobe clock |
| phyEnable | output | 1 | Test-port enable; high marks an address transfer |
| phyDin | output | CODE_W | Test-port data-in bus |
| busy | output | 1 | High while a write is being played out |
| done | output | 1 | One-cycle pulse after the last phase |

## Verification
The assertions check the edge rules on every cycle. These are: clear is only raised on an otherwise quiet port, enable only rises under a high strobe, data-in and enable stay still across every strobe edge, the port is silent while idle, and the run length and done pulse are exact. They also check that a busy run never grows past its nominal length, which catches a restart while busy. Only the bench scenarios can show that the right operand reaches data-in in the right phase, that phases come in the stated order with the stated lengths, and that a request dropped mid-write leaves the captured operands unchanged. The bench sweeps every code value and every data value through complete writes.

// File: rtl/phyTestWriterPkg.sv
package phyTestWriterPkg;

  // Phase order is behaviour: the PHY decodes edges in this sequence.
  typedef enum logic [2:0] {
    PH_CLEAR  = 3'd0,
    PH_GAP    = 3'd1,
    PH_RISE   = 3'd2,
    PH_ASETUP = 3'd3,
    PH_AFALL  = 3'd4,
    PH_DSETUP = 3'd5,
    PH_DRISE  = 3'd6,
    PH_TAIL   = 3'd7
  } phaseT;

  localparam int unsigned NUM_PHASES = 8;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;       // capture operands this cycle
    logic drvClear;   // drive the clear line
    logic drvStrobe;  // drive the strobe line
    logic drvEnable;  // drive the enable line
    logic selCode;    // data-in carries captured code
    logic selData;    // data-in carries captured value
  } ctlStrobesT;

endpackage

// File: rtl/phyTestWriterCtl.sv
module phyTestWriterCtl
  import phyTestWriterPkg::*;
#(
  parameter int HOLD_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  output ctlStrobesT ctl,
  output logic       busy,
  output logic       done
);

  localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

  phaseT            phase;
  logic [CNT_W-1:0] holdCnt;
  logic             active;
  logic             doneQ;
  logic             accept;
  logic             phaseEnd;
  logic             lastPhase;

  assign accept    = startReq && !active;
  assign phaseEnd  = active && (holdCnt == CNT_LAST);
  assign lastPhase = (phase == PH_TAIL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      phase   <= PH_CLEAR;
      holdCnt <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= phaseEnd && lastPhase;
      if (accept) begin
        active  <= 1'b1;
        phase   <= PH_CLEAR;
        holdCnt <= '0;
      end else if (active) begin
        if (phaseEnd) begin
          holdCnt <= '0;
          if (lastPhase) begin
            active <= 1'b0;
            phase  <= PH_CLEAR;
          end else begin
            phase <= phaseT'(3'(phase) + 3'd1);
          end
        end else begin
          holdCnt <= holdCnt + CNT_W'(1);
        end
      end
    end
  end

  always_comb begin
    ctl      = '0;
    ctl.load = accept;
    if (active) begin
      case (phase)
        PH_CLEAR:  ctl.drvClear = 1'b1;
        PH_GAP:    ;
        PH_RISE:   ctl.drvStrobe = 1'b1;
        PH_ASETUP: begin
          ctl.drvStrobe = 1'b1;
          ctl.drvEnable = 1'b1;
          ctl.selCode   = 1'b1;
        end
        PH_AFALL: begin
          ctl.drvEnable = 1'b1;
          ctl.selCode   = 1'b1;
        end
        PH_DSETUP: ctl.selData = 1'b1;
        PH_DRISE: begin
          ctl.drvStrobe = 1'b1;
          ctl.selData   = 1'b1;
        end
        PH_TAIL:   ctl.selData = 1'b1;
        default:   ctl = '0;
      endcase
    end
  end

  assign busy = active;
  assign done = doneQ;

endmodule

// File: rtl/phyTestWriterDp.sv
module phyTestWriterDp
  import phyTestWriterPkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobesT        ctl,
  input  logic [CODE_W-1:0] testCode,
  input  logic [CODE_W-1:0] testData,
  output logic              phyClear,
  output logic              phyStrobe,
  output logic              phyEnable,
  output logic [CODE_W-1:0] phyDin
);

  logic [CODE_W-1:0] codeQ;
  logic [CODE_W-1:0] dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeQ <= '0;
      dataQ <= '0;
    end else if (ctl.load) begin
      codeQ <= testCode;
      dataQ <= testData;
    end
  end

  always_comb begin
    phyDin = '0;
    if (ctl.selCode) phyDin = codeQ;
    else if (ctl.selData) phyDin = dataQ;
  end

  assign phyClear  = ctl.drvClear;
  assign phyStrobe = ctl.drvStrobe;
  assign phyEnable = ctl.drvEnable;

endmodule

// File: rtl/phyTestWriter.sv
module phyTestWriter
  import phyTestWriterPkg::*;
#(
  parameter int HOLD_CYCLES = 2,
  parameter int CODE_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [CODE_W-1:0] testCode,
  input  logic [CODE_W-1:0] testData,
  output logic              phyClear,
  output logic              phyStrobe,
  output logic              phyEnable,
  output logic [CODE_W-1:0] phyDin,
  output logic              busy,
  output logic              done
);

  ctlStrobesT ctlBus;

  phyTestWriterCtl #(.HOLD_CYCLES(HOLD_CYCLES)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .ctl      (ctlBus),
    .busy     (busy),
    .done     (done)
  );

  phyTestWriterDp #(.CODE_W(CODE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctlBus),
    .testCode  (testCode),
    .testData  (testData),
    .phyClear  (phyClear),
    .phyStrobe (phyStrobe),
    .phyEnable (phyEnable),
    .phyDin    (phyDin)
  );

endmodule

// File: rtl/phyTestWriterChk.sv
module phyTestWriterChk
  import phyTestWriterPkg::*;
#(
  parameter int HOLD_CYCLES = 2,
  parameter int CODE_W      = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic              busy,
  input logic              done,
  input logic              phyClear,
  input logic              phyStrobe,
  input logic              phyEnable,
  input logic [CODE_W-1:0] phyDin
);

  localparam int TOTAL = int'(NUM_PHASES) * HOLD_CYCLES;

  int runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= 0;
    else       runLen <= busy ? runLen + 1 : 0;
  end

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    startReq && !busy |=> busy); // R1

  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    phyClear |-> !phyStrobe && !phyEnable && (phyDin == '0)); // R2

  AST_ENABLE_UNDER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phyEnable) |-> phyStrobe && $stable(phyStrobe)); // R4

  AST_FALL_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(phyStrobe) |-> $stable(phyDin) && $stable(phyEnable)); // R4

  AST_RISE_DATA_MODE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phyStrobe) |-> !phyEnable && $stable(phyDin)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !phyClear && !phyStrobe && !phyEnable && (phyDin == '0)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && (runLen == TOTAL)); // R8

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> runLen < TOTAL); // R9

endmodule

bind phyTestWriter phyTestWriterChk #(
  .HOLD_CYCLES(HOLD_CYCLES),
  .CODE_W     (CODE_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startReq  (startReq),
  .busy      (busy),
  .done      (done),
  .phyClear  (phyClear),
  .phyStrobe (phyStrobe),
  .phyEnable (phyEnable),
  .phyDin    (phyDin)
);

// File: tb/phyTestWriter_bench.sv
module phyTestWriter_bench;

  localparam int HOLD  = 2;
  localparam int W     = 8;
  localparam int TOTAL = 8 * HOLD;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startReq = 1'b0;
  logic [W-1:0] testCode = '0;
  logic [W-1:0] testData = '0;
  logic         phyClear, phyStrobe, phyEnable, busy, done;
  logic [W-1:0] phyDin;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  phyTestWriter #(.HOLD_CYCLES(HOLD), .CODE_W(W)) u_phyTestWriter (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .testCode(testCode), .testData(testData),
    .phyClear(phyClear), .phyStrobe(phyStrobe), .phyEnable(phyEnable),
    .phyDin(phyDin), .busy(busy), .done(done)
  );

  // {busy, done, clear, strobe, enable, din}
  function automatic logic [12:0] observed();
    return {busy, done, phyClear, phyStrobe, phyEnable, phyDin};
  endfunction

  task automatic check(input bit ok, input string req, input logic [12:0] act,
                       input logic [12:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic runWrite(input logic [W-1:0] c, input logic [W-1:0] d,
                          input bit inject);
    logic [12:0] exp;
    string req;
    @(negedge clk);
    testCode = c; testData = d; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    for (int k = 0; k < TOTAL; k++) begin
      int ph;
      logic clr, stb, en;
      logic [W-1:0] din;
      if (k > 0) @(negedge clk);
      ph  = k / HOLD;
      clr = (ph == 0);
      stb = (ph == 2) || (ph == 3) || (ph == 6);
      en  = (ph == 3) || (ph == 4);
      din = (ph == 3 || ph == 4) ? c : (ph >= 5) ? d : '0;
      exp = {1'b1, 1'b0, clr, stb, en, din};
      case (ph)
        0: req = (k == 0) ? "R1" : "R2";
        1, 2: req = "R3";
        3, 4: req = "R4";
        5, 6: req = "R5";
        default: req = "R6";
      endcase
      if (inject && k > 3) req = {req, "/R9"};
      check(observed() == exp, req, observed(), exp);
      if (inject && k == 3) begin
        startReq = 1'b1; testCode = ~c; testData = ~d;
      end
      if (inject && k == 4) startReq = 1'b0;
    end
    @(negedge clk);
    exp = {1'b0, 1'b1, 11'h000};
    check(observed() == exp, "R8 done", observed(), exp);
    @(negedge clk);
    exp = 13'h0;
    check(observed() == exp, "R8 R6 R7 idle", observed(), exp);
    if (inject) begin
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        check(observed() == 13'h0, "R9 no second write", observed(), 13'h0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog act=%h exp=%h", 1'b0, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(observed() == 13'h0, "R7 in reset", observed(), 13'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(observed() == 13'h0, "R7 after reset", observed(), 13'h0);
    // Every code value.
    for (int i = 0; i < 256; i++)
      runWrite(W'(i), W'((i * 37 + 11) & 8'hff), 1'b0);
    // Every data value under the frequency-range select code.
    for (int i = 0; i < 256; i++)
      runWrite(8'h44, W'(i), 1'b0);
    // Requests dropped while busy.
    runWrite(8'hA5, 8'h3C, 1'b1);
    runWrite(8'h00, 8'hFF, 1'b1);
    runWrite(8'hFF, 8'h00, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule